// File: doc/BRIEF.md
# Fixed Off-Time Winding Current Chopper

This block regulates the current of one motor bridge with a fixed off-time scheme. A digital flag from an external comparator says when the sensed winding current has climbed past its reference. When that flag is honoured, the block raises a chop request. The request tells the gate sequencer to put the bridge into its recirculation phase for a programmed number of clock cycles. When that count runs out, the request drops and the bridge is driven again.

Each drive phase opens with a blanking window, in which the comparator is ignored so that the switching spike after turn-on cannot cause a false trip. A minimum drive length is also enforced. A trip that arrives before that length has passed is remembered, and it is acted on once the length is reached, even if the comparator has fallen back by then. All three timings are configuration inputs given in clock counts. Any dead time the gate sequencer inserts comes on top of the programmed off count. The comparator flag is asynchronous and goes through a two-stage synchronizer. The bridge-active qualifier is synchronous, and when it is low the block is forced to rest.

Top module: `coff_chopper`

## Requirements
- R1: While `bridge_en` is low, `chop_off` is 0 from the next clock onward and no chop starts, whatever `sense_hi` does. Dropping `bridge_en` during an off phase ends it after one clock.
- R2: `sense_hi` passes through two synchronizer flops. In a drive phase past blanking, with the minimum drive length already met, `chop_off` reads 1 in the third cycle after `sense_hi` rises.
- R3: An off phase lasts exactly max(`cfg_off`,1) cycles of `chop_off`=1, after which `chop_off` returns to 0 while the bridge stays active.
- R4: The synchronized comparator is ignored during the first `cfg_blank` cycles of every drive phase. A comparator pulse lying wholly inside that window causes no chop.
- R5: A drive phase (`chop_off`=0 with the bridge active) lasts at least max(`cfg_min_on`,1) cycles. A qualified trip seen earlier is held and causes a chop exactly when that length is reached, even if the comparator has gone low again.
- R6: `chop_start` is a single-cycle pulse. It is 1 exactly in the first cycle of each off phase.
- R7: After reset, `chop_off` and `chop_start` are 0.
- R8: With the comparator held high, each drive phase lasts max(`cfg_min_on`, `cfg_blank`+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_en | input | 1 | Bridge active qualifier (synchronous) |
| sense_hi | input | 1 | Comparator flag, sensed current above reference (asynchronous) |
| cfg_off | input | CNT_W | Off-phase length in cycles |
| cfg_blank | input | CNT_W | Blanking length in cycles at the start of each drive phase |
| cfg_min_on | input | CNT_W | Minimum drive-phase length in cycles |
| chop_off | output | 1 | Chop request, 1 during the recirculation phase |
| chop_start | output | 1 | One-cycle marker of each chop start |

## Verification
Several rules are checked by the assertions on every cycle. The request drops once the bridge is inactive. The start marker is a lone pulse that lines up with each rising request. A drive phase never ends before its minimum count. An off phase never ends before its programmed count. A blanked drive phase with no held trip never chops. Other behaviour can only be shown by the bench scenarios, which measure whole phase lengths at the ports. These are the three-cycle trip latency, the drive length with the comparator held high under different settings, the swallowing of a pulse inside the blanking window, and a held trip firing after the comparator has fallen.

// File: rtl/coff_pkg.sv
package coff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ON_BLANK = 2'd1,
        ST_ON_ARMED = 2'd2,
        ST_OFF      = 2'd3
    } chop_state_e;

    typedef struct packed {
        chop_state_e state;
        logic        pend;
        logic        start;
    } chop_regs_t;

endpackage

// File: rtl/coff_sync.sv
module coff_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/coff_span_counter.sv
module coff_span_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 count_q <= '0;
        else if (clr)               count_q <= '0;
        else if (count_q != '1)     count_q <= count_q + CNT_W'(1);
    end

    assign count = count_q;
endmodule

// File: rtl/coff_chopper.sv
module coff_chopper
    import coff_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bridge_en,
    input  logic             sense_hi,
    input  logic [CNT_W-1:0] cfg_off,
    input  logic [CNT_W-1:0] cfg_blank,
    input  logic [CNT_W-1:0] cfg_min_on,
    output logic             chop_off,
    output logic             chop_start
);
    localparam int EXT_W = CNT_W + 1;

    chop_regs_t       r_q, r_d;
    logic             sense_s;
    logic [CNT_W-1:0] on_cnt, off_cnt;
    logic [EXT_W-1:0] on_len, off_len;
    logic             in_on, min_ok, off_done, blank_done, trip, pend_nx;

    coff_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sense_hi), .q(sense_s)
    );

    assign in_on = (r_q.state == ST_ON_BLANK) || (r_q.state == ST_ON_ARMED);

    coff_span_counter #(.CNT_W(CNT_W)) u_on_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!in_on), .count(on_cnt)
    );

    coff_span_counter #(.CNT_W(CNT_W)) u_off_cnt (
        .clk(clk), .rst_n(rst_n), .clr(r_q.state != ST_OFF), .count(off_cnt)
    );

    // Lengths including the current cycle.
    assign on_len     = {1'b0, on_cnt}  + {{CNT_W{1'b0}}, 1'b1};
    assign off_len    = {1'b0, off_cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign min_ok     = on_len  >= {1'b0, cfg_min_on};
    assign off_done   = off_len >= {1'b0, cfg_off};
    assign blank_done = on_len  >= {1'b0, cfg_blank};
    assign trip       = sense_s && (on_cnt >= cfg_blank);
    assign pend_nx    = r_q.pend || trip;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.pend  = 1'b0;
                r_d.state = (cfg_blank == '0) ? ST_ON_ARMED : ST_ON_BLANK;
            end
            ST_ON_BLANK, ST_ON_ARMED: begin
                r_d.pend = pend_nx;
                if (pend_nx && min_ok) begin
                    r_d.state = ST_OFF;
                    r_d.pend  = 1'b0;
                    r_d.start = 1'b1;
                end else if (blank_done) begin
                    r_d.state = ST_ON_ARMED;
                end
            end
            ST_OFF: begin
                if (off_done)
                    r_d.state = (cfg_blank == '0) ? ST_ON_ARMED : ST_ON_BLANK;
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (!bridge_en) begin
            r_d.state = ST_IDLE;
            r_d.pend  = 1'b0;
            r_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, pend: 1'b0, start: 1'b0};
        else        r_q <= r_d;
    end

    assign chop_off   = (r_q.state == ST_OFF);
    assign chop_start = r_q.start;

    // Inactive bridge forces the request low on the next cycle.
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |=> !chop_off);

    // Off phase cannot end early while its count is unreached.
    assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_off && bridge_en && !off_done) |=> chop_off);

    // Blanked drive phase with no held trip never chops.
    assert_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ON_BLANK && !r_q.pend && !(on_cnt >= cfg_blank)) |=> !chop_off);

    // Drive phase never ends before the minimum length.
    assert_min_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_on && !min_ok) |=> !chop_off);

    // Start marker is a lone pulse aligned with each rising request.
    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chop_start |=> !chop_start);
    assert_start_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chop_off) |-> chop_start);
    assert_start_in_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chop_start |-> chop_off);
endmodule

// File: tb/coff_chopper_bench.sv
module coff_chopper_bench;
    localparam int CNT_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bridge_en = 1'b0;
    logic             sense_hi = 1'b0;
    logic [CNT_W-1:0] cfg_off = 20;
    logic [CNT_W-1:0] cfg_blank = 3;
    logic [CNT_W-1:0] cfg_min_on = 10;
    logic             chop_off, chop_start;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    coff_chopper #(.CNT_W(CNT_W)) u_coff_chopper (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .sense_hi(sense_hi),
        .cfg_off(cfg_off), .cfg_blank(cfg_blank), .cfg_min_on(cfg_min_on),
        .chop_off(chop_off), .chop_start(chop_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts negedges until chop_off equals lvl (1 = seen at the first negedge).
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            n++;
            if (chop_off == lvl) return;
        end
        n = -1;
    endtask

    // Called at a negedge where chop_off == lvl; counts the run length.
    task automatic run_len(input logic lvl, output int n);
        n = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (chop_off != lvl) return;
            n++;
        end
    endtask

    task automatic stop_bridge();
        @(negedge clk);
        bridge_en = 1'b0;
        sense_hi  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R7 chop_off after reset", int'(chop_off), 0);
        chk("R7 chop_start after reset", int'(chop_start), 0);
    endtask

    task automatic t_inactive();
        int highs = 0;
        @(negedge clk);
        sense_hi = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (chop_off || chop_start) highs++;
        end
        chk("R1 no chop while bridge inactive", highs, 0);
        sense_hi = 1'b0;
    endtask

    task automatic t_steady_high();
        int n, len, starts;
        cfg_off = 20; cfg_blank = 3; cfg_min_on = 10;
        @(negedge clk);
        bridge_en = 1'b1;
        sense_hi  = 1'b1;
        wait_level(1'b1, n);
        chk("R6 chop_start on first off cycle", int'(chop_start), 1);
        run_len(1'b1, len);
        chk("R3 off length 20", len, 20);
        chk("R6 chop_start low after first off cycle", int'(chop_start), 0);
        run_len(1'b0, len);
        chk("R8 on length min_on dominated (10)", len, 10);
        starts = 0;
        for (int i = 0; i < 30; i++) begin
            if (chop_start) starts++;
            @(negedge clk);
        end
        chk("R6 one start pulse per off phase", starts, 1);
        stop_bridge();
    endtask

    task automatic t_blank_dominated();
        int n, len;
        cfg_off = 5; cfg_blank = 6; cfg_min_on = 1;
        @(negedge clk);
        bridge_en = 1'b1;
        sense_hi  = 1'b1;
        wait_level(1'b1, n);
        run_len(1'b1, len);
        chk("R3 off length 5", len, 5);
        run_len(1'b0, len);
        chk("R8 on length blank dominated (7)", len, 7);
        stop_bridge();
    endtask

    task automatic t_off_one();
        int n, len;
        cfg_off = 1; cfg_blank = 0; cfg_min_on = 4;
        @(negedge clk);
        bridge_en = 1'b1;
        sense_hi  = 1'b1;
        wait_level(1'b1, n);
        run_len(1'b1, len);
        chk("R3 off length boundary 1", len, 1);
        run_len(1'b0, len);
        chk("R5 on length min 4", len, 4);
        stop_bridge();
    endtask

    task automatic t_blank_ignore();
        int n, len;
        cfg_off = 4; cfg_blank = 6; cfg_min_on = 1;
        @(negedge clk);
        bridge_en = 1'b1;
        sense_hi  = 1'b1;
        wait_level(1'b1, n);
        sense_hi = 1'b0;
        run_len(1'b1, len);
        // Now in the first drive cycle: pulse sense for two cycles.
        sense_hi = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sense_hi = 1'b0;
        wait_level(1'b1, n);
        chk("R4 pulse inside blanking ignored", (n == -1) ? 0 : 1, 0);
        stop_bridge();
    endtask

    task automatic t_held_trip();
        int n, len;
        cfg_off = 4; cfg_blank = 0; cfg_min_on = 8;
        @(negedge clk);
        bridge_en = 1'b1;
        sense_hi  = 1'b1;
        wait_level(1'b1, n);
        sense_hi = 1'b0;
        run_len(1'b1, len);
        sense_hi = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sense_hi = 1'b0;
        // Two drive cycles already elapsed.
        wait_level(1'b1, n);
        chk("R5 held trip fires at min on length", n + 2, 8);
        stop_bridge();
    endtask

    task automatic t_latency();
        int n, len;
        cfg_off = 6; cfg_blank = 0; cfg_min_on = 1;
        @(negedge clk);
        bridge_en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 no chop without trip", int'(chop_off), 0);
        sense_hi = 1'b1;
        wait_level(1'b1, n);
        chk("R2 trip to request latency", n, 3);
        sense_hi = 1'b0;
        run_len(1'b1, len);
        chk("R3 off length 6", len, 6);
        stop_bridge();
    endtask

    task automatic t_drop_in_off();
        int n;
        cfg_off = 50; cfg_blank = 2; cfg_min_on = 3;
        @(negedge clk);
        bridge_en = 1'b1;
        sense_hi  = 1'b1;
        wait_level(1'b1, n);
        repeat (3) @(negedge clk);
        chk("R3 still off mid phase", int'(chop_off), 1);
        bridge_en = 1'b0;
        @(negedge clk);
        chk("R1 off phase ends after bridge drop", int'(chop_off), 0);
        repeat (20) @(negedge clk);
        chk("R1 stays idle while inactive", int'(chop_off), 0);
        sense_hi = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inactive();
        t_steady_high();
        t_blank_dominated();
        t_off_one();
        t_blank_ignore();
        t_held_trip();
        t_latency();
        t_drop_in_off();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule